// File: doc/BRIEF.md
# Optical disc sector preprocessor

This block sits between a disc front end that delivers sectors one byte per accepted transfer and a memory that holds a circular buffer of half-word locations. It tracks the byte position inside each sector, throws away header and check bytes, and packs the retained user bytes two at a time into 16-bit writes. Each retained sector is written from the start of a fresh buffer segment. Once the sector's last byte has arrived, the block announces that segment as filled through a one-cycle commit pulse that carries the segment's base address.

A mode input selects between two sector formats. The first is a 2064-byte sector whose 2048 payload bytes are kept. The second is a 2352-byte sector carrying an extended subheader. In that format the submode byte decides whether the sector is kept. The segment size is 1024 half-words for the first format and 2048 half-words for the second. A consumer frees filled segments one at a time. While every segment of the buffer holds committed data that has not been released, the block stops accepting input bytes.

Top module: `sector_preproc`

## Requirements
- R1: With `in_mode`=0, a 2064-byte sector has its bytes 0..11 and 2060..2063 discarded, and only bytes 12..2059 are written.
- R2: Retained bytes are paired in arrival order. The earlier byte of a pair goes to `wr_data[15:8]` and the later byte to `wr_data[7:0]`. Successive pairs go to successive half-word addresses, starting at the segment base. A write appears on the port in the cycle after the byte that completes it is accepted.
- R3: Every kept sector begins at a segment base. Each commit advances the base by 1024 half-words when `in_mode`=0 and by 2048 half-words when `in_mode`=1. `commit_valid` pulses for one cycle, in the cycle after the sector's last byte is accepted, with `commit_base` equal to that sector's base.
- R4: With `in_mode`=1, a 2352-byte sector carries its submode byte at byte 18. When bit 5 of that byte is 0, the sector is kept, and bytes 24..2071 (2048 bytes) are written.
- R5: With `in_mode`=1, when submode bit 5 is 1 and either bit 1 (video) or bit 2 (audio) is 1, the sector is kept, and bytes 24..2347 (2324 bytes) are written.
- R6: With `in_mode`=1, a sector whose submode has bit 5 set but neither bit 1 nor bit 2 causes no write and no commit, and the base stays where it was.
- R7: An `in_start` byte accepted before the current sector has completed abandons that sector. It gets no commit, and the new sector is written from the same base at offset 0. A half-filled pending pair is dropped.
- R8: `in_ready` is low exactly while the number of committed, unreleased segments equals the buffer size divided by the current segment size. No byte is taken while it is low, and each `rd_release` pulse frees one segment.
- R9: Segment bases and write addresses wrap modulo the buffer size `BUF_HW`.
- R10: Bytes presented with `in_valid` but without `in_start`, after a sector has completed, are ignored. They cause no write and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_mode | input | 1 | Sector format: 0 = 2064-byte, 1 = 2352-byte with subheader |
| in_valid | input | 1 | Input byte present |
| in_start | input | 1 | Marks the present byte as byte 0 of a sector |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted at this edge when high together with in_valid |
| rd_release | input | 1 | Consumer frees one committed segment |
| wr_en | output | 1 | Half-word write request |
| wr_addr | output | $clog2(BUF_HW) | Half-word address |
| wr_data | output | 16 | Half-word data |
| commit_valid | output | 1 | A sector has been completely written |
| commit_base | output | $clog2(BUF_HW) | Base address of the committed segment |

## Verification
The bench builds the block with `BUF_HW` = 4096. This gives four segments in the 2064-byte format and two in the 2352-byte format. At that size, five full sectors are enough to fill the buffer, to hold the input while it is full, and to bring the base back to address 0. The base also wraps in the middle of the subheader-format sequence. Because of that, the dropped-sector case can be seen to leave the base unchanged across a wrap.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic {
    FMT_PLAIN = 1'b0,
    FMT_XA    = 1'b1
  } fmt_e;

  localparam int IDX_W = 12;

  localparam int PLAIN_SEC_BYTES = 2064;
  localparam int PLAIN_PAY_FIRST = 12;
  localparam int PLAIN_PAY_END   = 2060;
  localparam int PLAIN_SEG_HW    = 1024;

  localparam int XA_SEC_BYTES   = 2352;
  localparam int XA_SUBMODE_POS = 18;
  localparam int XA_PAY_FIRST   = 24;
  localparam int XA_F1_END      = XA_PAY_FIRST + 2048;
  localparam int XA_F2_END      = XA_PAY_FIRST + 2324;
  localparam int XA_SEG_HW      = 2048;

  localparam int SM_FORM2 = 5;
  localparam int SM_VIDEO = 1;
  localparam int SM_AUDIO = 2;

  function automatic logic [IDX_W-1:0] last_idx(fmt_e f);
    return (f == FMT_XA) ? IDX_W'(XA_SEC_BYTES - 1) : IDX_W'(PLAIN_SEC_BYTES - 1);
  endfunction

  function automatic logic [IDX_W-1:0] pay_first(fmt_e f);
    return (f == FMT_XA) ? IDX_W'(XA_PAY_FIRST) : IDX_W'(PLAIN_PAY_FIRST);
  endfunction

  function automatic logic [IDX_W-1:0] pay_end(fmt_e f, logic form2);
    if (f == FMT_PLAIN) return IDX_W'(PLAIN_PAY_END);
    return form2 ? IDX_W'(XA_F2_END) : IDX_W'(XA_F1_END);
  endfunction

  function automatic logic sector_wanted(logic [7:0] sm);
    return !sm[SM_FORM2] || sm[SM_VIDEO] || sm[SM_AUDIO];
  endfunction

  function automatic int unsigned seg_hw(fmt_e f);
    return (f == FMT_XA) ? XA_SEG_HW : PLAIN_SEG_HW;
  endfunction

  function automatic logic [15:0] hw_join(logic [7:0] hi, logic [7:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/sp_framer.sv
module sp_framer
  import sp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       start,
  input  fmt_e       fmt_in,
  input  logic [7:0] byte_in,
  output logic       pay_v,
  output logic       last_v,
  output logic       keep_v,
  output logic       sec_open,
  output logic       drop_o,
  output fmt_e       fmt_o
);

  logic             active_q;
  logic [IDX_W-1:0] cnt_q;
  fmt_e             fmt_q;
  logic             form2_q;
  logic             drop_q;

  logic             in_sec;
  logic [IDX_W-1:0] idx;
  fmt_e             cur_fmt;
  logic             cur_form2;
  logic             cur_drop;
  logic             at_sub;

  always_comb begin
    in_sec    = take && (start || active_q);
    idx       = start ? '0 : cnt_q;
    cur_fmt   = start ? fmt_in : fmt_q;
    cur_form2 = start ? 1'b0 : form2_q;
    cur_drop  = start ? 1'b0 : drop_q;
    at_sub    = (cur_fmt == FMT_XA) && (idx == IDX_W'(XA_SUBMODE_POS));
    pay_v     = in_sec && !cur_drop && (idx >= pay_first(cur_fmt))
                && (idx < pay_end(cur_fmt, cur_form2));
    last_v    = in_sec && (idx == last_idx(cur_fmt));
    keep_v    = last_v && !cur_drop;
    sec_open  = take && start;
  end

  assign drop_o = drop_q;
  assign fmt_o  = cur_fmt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      fmt_q    <= FMT_PLAIN;
      form2_q  <= 1'b0;
      drop_q   <= 1'b0;
    end else if (in_sec) begin
      cnt_q    <= idx + 1'b1;
      fmt_q    <= cur_fmt;
      active_q <= !last_v;
      if (at_sub) begin
        form2_q <= byte_in[SM_FORM2];
        drop_q  <= !sector_wanted(byte_in);
      end else begin
        form2_q <= cur_form2;
        drop_q  <= cur_drop;
      end
    end
  end

endmodule

// File: rtl/sp_pack.sv
module sp_pack
  import sp_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pay_v,
  input  logic          flush,
  input  logic [7:0]    byte_in,
  input  logic [AW-1:0] base,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);

  logic          pend_q;
  logic [7:0]    hold_q;
  logic [AW-1:0] off_q;

  logic          pend_eff;
  logic [AW-1:0] off_eff;
  logic          emit;
  logic [15:0]   word;
  logic          nxt_pend;
  logic [7:0]    nxt_hold;
  logic [AW-1:0] nxt_off;

  always_comb begin
    pend_eff = restart ? 1'b0 : pend_q;
    off_eff  = restart ? '0 : off_q;
    emit     = 1'b0;
    word     = '0;
    nxt_pend = pend_eff;
    nxt_hold = hold_q;
    if (pay_v) begin
      if (pend_eff) begin
        emit     = 1'b1;
        word     = hw_join(hold_q, byte_in);
        nxt_pend = 1'b0;
      end else if (flush) begin
        emit = 1'b1;
        word = hw_join(byte_in, 8'h00);
      end else begin
        nxt_pend = 1'b1;
        nxt_hold = byte_in;
      end
    end else if (flush && pend_eff) begin
      emit     = 1'b1;
      word     = hw_join(hold_q, 8'h00);
      nxt_pend = 1'b0;
    end
    nxt_off = emit ? off_eff + 1'b1 : off_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      hold_q  <= '0;
      off_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      pend_q  <= nxt_pend;
      hold_q  <= nxt_hold;
      off_q   <= nxt_off;
      wr_en   <= emit;
      wr_addr <= base + off_eff;
      wr_data <= word;
    end
  end

endmodule

// File: rtl/sp_segctl.sv
module sp_segctl
  import sp_pkg::*;
#(
  parameter int BUF_HW = 16384,
  parameter int AW     = $clog2(BUF_HW),
  parameter int UW     = $clog2(BUF_HW / PLAIN_SEG_HW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt_now,
  input  logic          commit,
  input  fmt_e          commit_fmt,
  input  logic          release_seg,
  output logic          ready,
  output logic [AW-1:0] base_q,
  output logic [UW-1:0] used_q,
  output logic          commit_valid,
  output logic [AW-1:0] commit_base
);

  function automatic logic [UW-1:0] seg_count(fmt_e f);
    return UW'(BUF_HW / seg_hw(f));
  endfunction

  logic do_rel;

  assign ready  = used_q < seg_count(fmt_now);
  assign do_rel = release_seg && (used_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q       <= '0;
      used_q       <= '0;
      commit_valid <= 1'b0;
      commit_base  <= '0;
    end else begin
      commit_valid <= commit;
      if (commit) begin
        commit_base <= base_q;
        base_q      <= base_q + AW'(seg_hw(commit_fmt));
      end
      case ({commit, do_rel})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

endmodule

// File: rtl/sector_preproc.sv
module sector_preproc
  import sp_pkg::*;
#(
  parameter int BUF_HW = 16384,
  localparam int AW    = $clog2(BUF_HW),
  localparam int UW    = $clog2(BUF_HW / PLAIN_SEG_HW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_mode,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic          rd_release,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic          commit_valid,
  output logic [AW-1:0] commit_base
);

  fmt_e          mode_fmt;
  logic          byte_take;
  logic          pay_v;
  logic          last_v;
  logic          keep_v;
  logic          sec_open;
  logic          sec_drop;
  fmt_e          sec_fmt;
  logic [AW-1:0] seg_base;
  logic [UW-1:0] used_cnt;

  assign mode_fmt  = fmt_e'(in_mode);
  assign byte_take = in_valid && in_ready;

  sp_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (byte_take),
    .start    (in_start),
    .fmt_in   (mode_fmt),
    .byte_in  (in_data),
    .pay_v    (pay_v),
    .last_v   (last_v),
    .keep_v   (keep_v),
    .sec_open (sec_open),
    .drop_o   (sec_drop),
    .fmt_o    (sec_fmt)
  );

  sp_pack #(.AW(AW)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sec_open),
    .pay_v   (pay_v),
    .flush   (last_v),
    .byte_in (in_data),
    .base    (seg_base),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  sp_segctl #(.BUF_HW(BUF_HW), .AW(AW), .UW(UW)) u_seg (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_now      (mode_fmt),
    .commit       (keep_v),
    .commit_fmt   (sec_fmt),
    .release_seg  (rd_release),
    .ready        (in_ready),
    .base_q       (seg_base),
    .used_q       (used_cnt),
    .commit_valid (commit_valid),
    .commit_base  (commit_base)
  );

endmodule

// File: rtl/sp_chk.sv
module sp_chk
  import sp_pkg::*;
#(
  parameter int BUF_HW = 16384,
  localparam int AW    = $clog2(BUF_HW),
  localparam int UW    = $clog2(BUF_HW / PLAIN_SEG_HW + 1),
  localparam int MAX_SEG = BUF_HW / PLAIN_SEG_HW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_take,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] seg_base,
  input fmt_e          sec_fmt,
  input logic          sec_drop,
  input logic          commit_valid,
  input logic [UW-1:0] used_cnt
);

  logic [AW-1:0] base_d;
  logic [AW-1:0] span_d;
  logic [AW-1:0] rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_d <= '0;
      span_d <= AW'(PLAIN_SEG_HW);
    end else begin
      base_d <= seg_base;
      span_d <= AW'(seg_hw(sec_fmt));
    end
  end

  assign rel = wr_addr - base_d;

  a_r1_write_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_take));

  a_r2_write_in_segment: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rel < span_d));

  a_r3_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  a_r6_dropped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sec_drop |-> !wr_en);

  a_r8_used_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= UW'(MAX_SEG));

endmodule

bind sector_preproc sp_chk #(.BUF_HW(BUF_HW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_take    (byte_take),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .seg_base     (seg_base),
  .sec_fmt      (sec_fmt),
  .sec_drop     (sec_drop),
  .commit_valid (commit_valid),
  .used_cnt     (used_cnt)
);

// File: tb/sector_preproc_tb.sv
module sector_preproc_tb;

  localparam int BUF = 4096;
  localparam int AW  = $clog2(BUF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_mode = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_start = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready;
  logic          rd_release = 1'b0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic          commit_valid;
  logic [AW-1:0] commit_base;

  always #2 clk = ~clk;

  sector_preproc #(.BUF_HW(BUF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_mode(in_mode), .in_valid(in_valid),
    .in_start(in_start), .in_data(in_data), .in_ready(in_ready),
    .rd_release(rd_release), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_valid(commit_valid), .commit_base(commit_base)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wr_seen = 0;
  int cm_seen = 0;
  int b_base = 0;
  bit finished = 0;

  int    exp_addr[$];
  int    exp_data[$];
  string exp_tag[$];
  int    exp_cm[$];
  string exp_cm_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        wr_seen++;
        if (exp_addr.size() == 0) begin
          check(0, "R10", "unexpected write addr", int'(wr_addr), -1);
        end else begin
          automatic int    ea = exp_addr.pop_front();
          automatic int    ed = exp_data.pop_front();
          automatic string et = exp_tag.pop_front();
          check(int'(wr_addr) == ea, et, "R2 write address", int'(wr_addr), ea);
          check(int'(wr_data) == ed, et, "R2 write data", int'(wr_data), ed);
        end
      end
      if (commit_valid) begin
        cm_seen++;
        if (exp_cm.size() == 0) begin
          check(0, "R3", "unexpected commit", int'(commit_base), -1);
        end else begin
          automatic int    eb = exp_cm.pop_front();
          automatic string et = exp_cm_tag.pop_front();
          check(int'(commit_base) == eb, et, "R3 commit base", int'(commit_base), eb);
        end
      end
    end
  end

  function automatic logic [7:0] byte_val(bit xa, logic [7:0] sm, int i, int seed);
    if (xa && i == 18) return sm;
    return 8'((i * 13 + seed) & 255);
  endfunction

  task automatic drive_byte(input logic [7:0] b, input bit st);
    @(negedge clk);
    in_valid = 1'b1;
    in_start = st;
    in_data  = b;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic settle();
    idle();
    repeat (3) @(negedge clk);
  endtask

  task automatic release_one();
    @(negedge clk);
    rd_release = 1'b1;
    @(negedge clk);
    rd_release = 1'b0;
  endtask

  // driver: pushes expectations, then sends the bytes
  task automatic send_sector(input bit xa, input logic [7:0] sm, input int n_send,
                             input int seed, input string tag);
    int  len   = xa ? 2352 : 2064;
    int  lo    = xa ? 24 : 12;
    bit  form2 = xa && sm[5];
    int  hi    = !xa ? 2060 : (form2 ? 2348 : 2072);
    bit  keep  = !xa || !sm[5] || sm[1] || sm[2];
    int  segl  = xa ? 2048 : 1024;
    if (keep) begin
      for (int p = lo; (p + 1 < hi) && (p + 1 < n_send); p += 2) begin
        exp_addr.push_back((b_base + (p - lo) / 2) % BUF);
        exp_data.push_back({byte_val(xa, sm, p, seed), byte_val(xa, sm, p + 1, seed)});
        exp_tag.push_back(tag);
      end
      if (n_send == len) begin
        exp_cm.push_back(b_base);
        exp_cm_tag.push_back(tag);
        b_base = (b_base + segl) % BUF;
      end
    end
    for (int i = 0; i < n_send; i++) drive_byte(byte_val(xa, sm, i, seed), i == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int c0;
    int k0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R8", "ready after reset", int'(in_ready), 1);
    check(wr_en === 1'b0, "R1", "no write after reset", int'(wr_en), 0);
    check(commit_valid === 1'b0, "R3", "no commit after reset", int'(commit_valid), 0);

    // plain format, two whole sectors
    send_sector(0, 8'h00, 2064, 3, "R1");
    send_sector(0, 8'h00, 2064, 5, "R3");
    // R7: abandoned sector (odd byte pending) then a full one on the same base
    send_sector(0, 8'h00, 601, 7, "R7");
    send_sector(0, 8'h00, 2064, 9, "R7");
    settle();
    check(cm_seen == 3, "R7", "commits after abandon", cm_seen, 3);

    // R10: stray bytes outside any sector
    c0 = wr_seen;
    for (int i = 0; i < 40; i++) drive_byte(8'(i + 100), 1'b0);
    settle();
    check(wr_seen == c0, "R10", "writes from stray bytes", wr_seen, c0);
    check(cm_seen == 3, "R10", "commits from stray bytes", cm_seen, 3);

    // R8: fill the four segments
    send_sector(0, 8'h00, 2064, 11, "R3");
    settle();
    check(in_ready == 1'b0, "R8", "ready when full", int'(in_ready), 0);
    c0 = wr_seen;
    fork
      send_sector(0, 8'h00, 2064, 13, "R9");
      begin
        repeat (40) @(negedge clk);
        check(wr_seen == c0, "R8", "writes while full", wr_seen, c0);
        check(in_ready == 1'b0, "R8", "ready held low", int'(in_ready), 0);
        release_one();
      end
    join
    settle();
    check(cm_seen == 5, "R9", "wrapped sector committed", cm_seen, 5);
    repeat (4) release_one();
    settle();
    check(in_ready == 1'b1, "R8", "ready after releases", int'(in_ready), 1);

    // subheader format
    in_mode = 1'b1;
    send_sector(1, 8'h08, 2352, 21, "R4");
    settle();
    release_one();
    send_sector(1, 8'h22, 2352, 23, "R5");
    settle();
    release_one();
    c0 = wr_seen;
    k0 = cm_seen;
    send_sector(1, 8'h28, 2352, 25, "R6");
    settle();
    check(wr_seen == c0, "R6", "writes from dropped sector", wr_seen, c0);
    check(cm_seen == k0, "R6", "commit from dropped sector", cm_seen, k0);
    send_sector(1, 8'h24, 2352, 27, "R5");
    settle();
    release_one();
    settle();

    check(exp_addr.size() == 0, "R2", "writes still expected", exp_addr.size(), 0);
    check(exp_cm.size() == 0, "R3", "commits still expected", exp_cm.size(), 0);
    finish_run();
  end

endmodule